// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block maps a 14-bit virtual address to a 16-bit physical address through a small bank of per-segment registers. The two top address bits choose one of three live segments: code, heap or stack. The remaining twelve bits form an offset. The block checks the offset against the segment size, combines it with the segment base, and tests it against the segment's access rights. Each segment also holds a growth-direction bit. A segment that grows downward uses the offset counted back from the 4 KB segment ceiling, so the physical address falls below the base.

Software loads the segment registers through a configuration write port. A write takes effect only when it is flagged privileged. Translation requests arrive on a valid-qualified request port, and each one returns exactly one registered response one cycle later. The response carries either a physical address or a fault code.

Top module: `seg_xlate`

## Requirements
- R1: The segment selector is virtual address bits [13:12] and the offset is bits [11:0]. Selector 0 is code, 1 is heap and 3 is stack.
- R2: For an upward-growing segment the physical address is base + offset. A BOUNDS fault is reported when offset >= size.
- R3: For a downward-growing segment, let m = 4096 - offset. The physical address is base - m. A BOUNDS fault is reported when m > size.
- R4: Each segment has permission bits: bit0 read, bit1 write, bit2 execute. The access type is 0 read, 1 write, 2 execute and 3 reserved. An access whose permission bit is clear gives a PROTECTION fault, and the reserved type always does.
- R5: Selector 2 always gives a BAD_SEGMENT fault. The fault priority is BAD_SEGMENT first, then BOUNDS, then PROTECTION.
- R6: The fault codes are NONE=0, BOUNDS=1, PROTECTION=2, PRIVILEGE=3 and BAD_SEGMENT=4. Whenever a response carries a fault other than NONE, its physical address is 0.
- R7: rsp_valid_o is high in the cycle after a cycle with req_valid_i high, and low otherwise. The response reflects that request.
- R8: A privileged configuration write replaces the base, size, direction and permissions of the selected segment, and requests from the next cycle on see the new values. A request presented in the same cycle as the write is translated with the old values.
- R9: A configuration write with cfg_priv_i low changes no register, and cfg_fault_o shows PRIVILEGE (3) in the next cycle. Otherwise cfg_fault_o is NONE. A privileged write to selector 2 changes nothing.
- R10: After reset the segments hold these values:
  - code: base 32768, size 2048, upward, permission 3'b101.
  - heap: base 34816, size 2048, upward, permission 3'b011.
  - stack: base 28672, size 2048, downward, permission 3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Segment register write strobe |
| cfg_priv_i | input | 1 | Write is issued in privileged mode |
| cfg_sel_i | input | 2 | Segment to write |
| cfg_base_i | input | 16 | New base |
| cfg_size_i | input | 13 | New size in bytes |
| cfg_up_i | input | 1 | New growth direction, 1 upward |
| cfg_perm_i | input | 3 | New permissions {x,w,r} |
| cfg_fault_o | output | 3 | Write result, PRIVILEGE or NONE |
| req_valid_i | input | 1 | Translation request valid |
| req_va_i | input | 14 | Virtual address |
| req_acc_i | input | 2 | Access type |
| rsp_valid_o | output | 1 | Response valid |
| rsp_pa_o | output | 16 | Physical address, 0 on fault |
| rsp_fault_o | output | 3 | Fault code |

## Verification
A configuration write and a translation request can land in the same cycle. The request may even target the segment being rewritten. The bench provokes this by driving both ports at once: it writes new code-segment rights that would allow a write, while it issues a code write request. It expects the PROTECTION result under the old rights, then expects a successful translation under the new values on the following request. The bench's behavioural model updates its segment table only after it has computed that cycle's expected response, so the ordering is judged without reference to the design's structure.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_BOUNDS = 3'd1,
    FLT_PROT   = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_BADSEG = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  function automatic int unsigned seg_rst_base(int idx);
    case (idx)
      0:       return 32768;
      1:       return 34816;
      3:       return 28672;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned seg_rst_size(int idx);
    return (idx == 2) ? 0 : 2048;
  endfunction

  function automatic logic seg_rst_up(int idx);
    return idx != 3;
  endfunction

  function automatic logic [2:0] seg_rst_perm(int idx);
    case (idx)
      0:       return 3'b101;
      1, 3:    return 3'b011;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int          SEL_W    = 2,
  parameter int          PA_W     = 16,
  parameter int          SIZE_W   = 13,
  parameter int          N_SEG    = 1 << SEL_W,
  parameter logic [N_SEG-1:0] SEG_USED = 4'b1011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [PA_W-1:0]   base_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              up_i,
  input  logic [2:0]        perm_i,
  output logic [PA_W-1:0]   base_o [N_SEG],
  output logic [SIZE_W-1:0] size_o [N_SEG],
  output logic              up_o   [N_SEG],
  output logic [2:0]        perm_o [N_SEG],
  output fault_e            fault_o
);
  logic wr_ok;
  assign wr_ok = we_i && priv_i;

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    if (SEG_USED[g]) begin : g_live
      logic hit;
      assign hit = wr_ok && (sel_i == SEL_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_o[g] <= PA_W'(seg_rst_base(g));
          size_o[g] <= SIZE_W'(seg_rst_size(g));
          up_o[g]   <= seg_rst_up(g);
          perm_o[g] <= seg_rst_perm(g);
        end else if (hit) begin
          base_o[g] <= base_i;
          size_o[g] <= size_i;
          up_o[g]   <= up_i;
          perm_o[g] <= perm_i;
        end
      end

      a_r9_unpriv_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !priv_i) |=> ($stable(base_o[g]) && $stable(size_o[g])
                               && $stable(up_o[g]) && $stable(perm_o[g])));
    end else begin : g_hole
      assign base_o[g] = '0;
      assign size_o[g] = '0;
      assign up_o[g]   = 1'b1;
      assign perm_o[g] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fault_o <= FLT_NONE;
    else if (we_i && !priv_i)   fault_o <= FLT_PRIV;
    else                        fault_o <= FLT_NONE;
  end

  a_r9_priv_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> (fault_o == FLT_PRIV));
endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
  import seg_xlate_pkg::*;
#(
  parameter int VA_W   = 14,
  parameter int SEL_W  = 2,
  parameter int PA_W   = 16,
  parameter int OFF_W  = VA_W - SEL_W,
  parameter int SIZE_W = OFF_W + 1,
  parameter int N_SEG  = 1 << SEL_W,
  parameter logic [N_SEG-1:0] SEG_USED = 4'b1011
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [1:0]        acc_i,
  input  logic [PA_W-1:0]   base_i [N_SEG],
  input  logic [SIZE_W-1:0] size_i [N_SEG],
  input  logic              up_i   [N_SEG],
  input  logic [2:0]        perm_i [N_SEG],
  output logic [PA_W-1:0]   pa_o,
  output fault_e            fault_o
);
  localparam logic [SIZE_W-1:0] SEG_SPAN = SIZE_W'(1) << OFF_W;

  logic [SEL_W-1:0]  sel;
  logic [OFF_W-1:0]  off;
  logic [SIZE_W-1:0] off_x, mag, size;
  logic [PA_W-1:0]   base;
  logic [2:0]        perm;
  logic              up, used, oob, perm_ok;

  assign sel   = va_i[VA_W-1 -: SEL_W];
  assign off   = va_i[OFF_W-1:0];
  assign off_x = {1'b0, off};
  assign base  = base_i[sel];
  assign size  = size_i[sel];
  assign up    = up_i[sel];
  assign perm  = perm_i[sel];
  assign used  = SEG_USED[sel];
  // distance below the segment ceiling for downward segments
  assign mag   = SEG_SPAN - off_x;
  assign oob   = up ? (off_x >= size) : (mag > size);

  always_comb begin
    case (acc_e'(acc_i))
      ACC_READ:  perm_ok = perm[PERM_R];
      ACC_WRITE: perm_ok = perm[PERM_W];
      ACC_EXEC:  perm_ok = perm[PERM_X];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    pa_o = '0;
    if (!used)         fault_o = FLT_BADSEG;
    else if (oob)      fault_o = FLT_BOUNDS;
    else if (!perm_ok) fault_o = FLT_PROT;
    else begin
      fault_o = FLT_NONE;
      pa_o    = up ? (base + PA_W'(off_x)) : (base - PA_W'(mag));
    end
  end
endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PA_W-1:0] pa_i,
  input  fault_e          fault_i,
  output logic            valid_o,
  output logic [PA_W-1:0] pa_o,
  output fault_e          fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pa_o    <= '0;
      fault_o <= FLT_NONE;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pa_o    <= pa_i;
        fault_o <= fault_i;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int SEL_W = 2,
  parameter int PA_W  = 16,
  parameter logic [(1<<SEL_W)-1:0] SEG_USED = 4'b1011
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic                  cfg_priv_i,
  input  logic [SEL_W-1:0]      cfg_sel_i,
  input  logic [PA_W-1:0]       cfg_base_i,
  input  logic [VA_W-SEL_W:0]   cfg_size_i,
  input  logic                  cfg_up_i,
  input  logic [2:0]            cfg_perm_i,
  output logic [2:0]            cfg_fault_o,
  input  logic                  req_valid_i,
  input  logic [VA_W-1:0]       req_va_i,
  input  logic [1:0]            req_acc_i,
  output logic                  rsp_valid_o,
  output logic [PA_W-1:0]       rsp_pa_o,
  output logic [2:0]            rsp_fault_o
);
  localparam int OFF_W  = VA_W - SEL_W;
  localparam int SIZE_W = OFF_W + 1;
  localparam int N_SEG  = 1 << SEL_W;

  logic [PA_W-1:0]   seg_base [N_SEG];
  logic [SIZE_W-1:0] seg_size [N_SEG];
  logic              seg_up   [N_SEG];
  logic [2:0]        seg_perm [N_SEG];
  fault_e            cfg_fault, lk_fault, rsp_fault;
  logic [PA_W-1:0]   lk_pa;

  seg_regfile #(
    .SEL_W(SEL_W), .PA_W(PA_W), .SIZE_W(SIZE_W), .N_SEG(N_SEG), .SEG_USED(SEG_USED)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .priv_i(cfg_priv_i), .sel_i(cfg_sel_i),
    .base_i(cfg_base_i), .size_i(cfg_size_i), .up_i(cfg_up_i), .perm_i(cfg_perm_i),
    .base_o(seg_base), .size_o(seg_size), .up_o(seg_up), .perm_o(seg_perm),
    .fault_o(cfg_fault)
  );

  seg_lookup #(
    .VA_W(VA_W), .SEL_W(SEL_W), .PA_W(PA_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W),
    .N_SEG(N_SEG), .SEG_USED(SEG_USED)
  ) u_lookup (
    .va_i(req_va_i), .acc_i(req_acc_i),
    .base_i(seg_base), .size_i(seg_size), .up_i(seg_up), .perm_i(seg_perm),
    .pa_o(lk_pa), .fault_o(lk_fault)
  );

  seg_rsp_stage #(.PA_W(PA_W)) u_rsp (
    .clk_i, .rst_ni,
    .valid_i(req_valid_i), .pa_i(lk_pa), .fault_i(lk_fault),
    .valid_o(rsp_valid_o), .pa_o(rsp_pa_o), .fault_o(rsp_fault)
  );

  assign cfg_fault_o = cfg_fault;
  assign rsp_fault_o = rsp_fault;

  a_r7_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r7_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r6_fault_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 3'd0) |-> (rsp_pa_o == '0));
  a_r5_bad_segment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !SEG_USED[req_va_i[VA_W-1 -: SEL_W]]) |=> (rsp_fault_o == 3'd4));
  a_r4_reserved_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_acc_i == 2'd3) |=> (rsp_fault_o != 3'd0));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_up = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_base = '0;
  logic [12:0] cfg_size = '0;
  logic [2:0]  cfg_perm = '0;
  logic [2:0]  cfg_fault;
  logic        req_valid = 1'b0;
  logic [13:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [15:0] rsp_pa;
  logic [2:0]  rsp_fault;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R7", exp_tag = "R7";

  int m_base[4], m_size[4], m_up[4], m_perm[4];
  bit exp_valid = 0;
  int exp_pa = 0, exp_fault = 0, exp_cfg = 0;

  always #10 clk = ~clk;

  seg_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_sel_i(cfg_sel),
    .cfg_base_i(cfg_base), .cfg_size_i(cfg_size), .cfg_up_i(cfg_up),
    .cfg_perm_i(cfg_perm), .cfg_fault_o(cfg_fault),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault)
  );

  task automatic model_reset();
    m_base = '{32768, 34816, 0, 28672};
    m_size = '{2048, 2048, 0, 2048};
    m_up   = '{1, 1, 1, 0};
    m_perm = '{5, 3, 0, 3};
  endtask

  function automatic void ref_xlate(input int va, input int acc, output int pa, output int f);
    int sel, off, mag;
    sel = va / 4096;
    off = va % 4096;
    pa = 0;
    if (sel == 2) f = 4;
    else if (m_up[sel] != 0 && off >= m_size[sel]) f = 1;
    else if (m_up[sel] == 0 && (4096 - off) > m_size[sel]) f = 1;
    else if (acc == 3 || ((m_perm[sel] >> acc) & 1) == 0) f = 2;
    else begin
      f = 0;
      mag = 4096 - off;
      pa = (m_up[sel] != 0) ? ((m_base[sel] + off) & 16'hFFFF)
                            : ((m_base[sel] - mag) & 16'hFFFF);
    end
  endfunction

  // reference model: response computed from the table before this edge's write
  always @(posedge clk) begin
    int p, f;
    if (!rst_n) begin
      model_reset();
      exp_valid = 0;
      exp_cfg = 0;
    end else begin
      exp_valid = req_valid;
      if (req_valid) begin
        ref_xlate(int'(req_va), int'(req_acc), p, f);
        exp_pa = p;
        exp_fault = f;
        exp_tag = cur_tag;
      end
      exp_cfg = (cfg_we && !cfg_priv) ? 3 : 0;
      if (cfg_we && cfg_priv && cfg_sel != 2'd2) begin
        m_base[cfg_sel] = int'(cfg_base);
        m_size[cfg_sel] = int'(cfg_size);
        m_up[cfg_sel]   = int'(cfg_up);
        m_perm[cfg_sel] = int'(cfg_perm);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7", int'(rsp_valid), int'(exp_valid), "rsp_valid");
      chk("R9", int'(cfg_fault), exp_cfg, "cfg_fault");
      if (exp_valid && rsp_valid) begin
        chk(exp_tag, int'(rsp_fault), exp_fault, "fault");
        chk(exp_tag, int'(rsp_pa), exp_pa, "pa");
      end
    end
  end

  task automatic req(input int va, input int acc, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_va = 14'(va); req_acc = 2'(acc); cur_tag = tag;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input int sel, input int base, input int size, input int up,
                     input int perm, input bit priv);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_sel = 2'(sel); cfg_base = 16'(base);
    cfg_size = 13'(size); cfg_up = 1'(up); cfg_perm = 3'(perm);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R7", int'(rsp_valid), 0, "reset rsp_valid");
    chk("R9", int'(cfg_fault), 0, "reset cfg_fault");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 / R1: reset table
    req(100, 0, "R10");
    req(4200, 0, "R1");
    req(15360, 0, "R10");
    // R2 upward bounds
    req(2047, 0, "R2");
    req(2048, 0, "R2");
    // R3 downward
    req(14336, 0, "R3");
    req(14335, 0, "R3");
    req(12288, 0, "R3");
    req(16383, 1, "R3");
    // R4 protection
    req(100, 1, "R4");
    req(100, 2, "R4");
    req(4200, 2, "R4");
    req(4200, 3, "R4");
    // R5 bad segment and priority, R6 zero address
    req(8192, 0, "R5");
    req(8197, 2, "R6");
    req(3000, 1, "R5");
    // R7 back-to-back
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      req_valid = 1'b1; req_va = 14'(4096 + i); req_acc = 2'd0; cur_tag = "R7";
      @(negedge clk);
    end
    req_valid = 1'b0;
    // R9 unprivileged write ignored
    cfg(1, 0, 4096, 1, 7, 1'b0);
    req(4200, 2, "R9");
    req(4200, 0, "R9");
    cfg(2, 100, 100, 1, 7, 1'b1);
    req(8192, 0, "R9");
    // R8 privileged update
    cfg(1, 1000, 100, 1, 7, 1'b1);
    req(4096 + 50, 2, "R8");
    req(4096 + 100, 0, "R8");
    // R8 write and request in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_sel = 2'd0; cfg_base = 16'd500;
    cfg_size = 13'd4096; cfg_up = 1'b1; cfg_perm = 3'b111;
    req_valid = 1'b1; req_va = 14'd100; req_acc = 2'd1; cur_tag = "R8";
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    req(100, 1, "R8");
    req(4095, 2, "R8");
    // R3 -> R2: stack turned upward
    cfg(3, 0, 4096, 1, 3, 1'b1);
    req(12288 + 10, 1, "R2");
    cfg(3, 40000, 4096, 0, 3, 1'b1);
    req(12288, 0, "R3");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule